// File: doc/BRIEF.md
# Keyed Super-IO Configuration Port

This block is the configuration front end of a multifunction Super-IO style device. A host reaches it through two byte locations. Writing to the first location selects a register index. Reading or writing the second location then moves data to or from that register. Configuration is closed after reset. A single key byte written to the index location opens it, and a second key byte closes it again.

Behind the index are a few global registers: a fixed chip identifier, a logical device selector, and a read-back of the port's own base address. There is also one bank of registers for each implemented logical device. The selector decides which bank the bank indices reach. Each bank carries an enable bit and a 16-bit I/O base. The infrared-style device also carries an interrupt number. These values drive the block's outputs towards the downstream functions.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed, the stored index is 0x00, the selected device number is 0x00, and every enable, I/O base and interrupt output is zero.
- R2: While closed, an index-location write of 0x5A opens the port. Any other index-location write leaves the port closed.
- R3: While open, an index-location write of 0xA5 closes the port and leaves the stored index unchanged.
- R4: While closed, a read of either location returns 0xFF, and data-location writes change no register.
- R5: While open, reading the index location (address bit 0) returns the last stored index. Opening the port sets the stored index to 0x00. Any other index-location write stores its byte.
- R6: Global index 0x00 reads 0xB7 and ignores writes.
- R7: Global index 0x26 reads the low byte and index 0x27 reads the high byte of the `PORT_BASE` parameter (default 0x002E). Both ignore writes.
- R8: Global index 0x07 is a read/write 8-bit logical device number that selects the bank reached by indices 0x30, 0x60, 0x61 and 0x70.
- R9: In the bank of device 5 (infrared) or device 9 (mailbox), bit 0 of index 0x30 is that device's enable. It reads back as {7'b0, enable} and drives the device's enable output.
- R10: In those banks, index 0x60 holds the high byte and index 0x61 the low byte of the device's I/O base, which drives its 16-bit base output.
- R11: Index 0x70 in the device-5 bank stores the low `IRQ_W` (default 4) bits of the written byte, reads them back zero-extended and drives the interrupt output. Device 9 has no index 0x70, so it reads 0x00 and ignores writes there.
- R12: Any other index, and any bank index while the device number is neither 5 nor 9, reads 0x00 and ignores writes.
- R13: Read data is combinational in the cycle of the read. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 selects the index location, 1 the data location |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, same cycle |
| ir_enable | output | 1 | Device 5 enable |
| ir_base | output | 16 | Device 5 I/O base |
| ir_irq | output | IRQ_W | Device 5 interrupt number |
| mbx_enable | output | 1 | Device 9 enable |
| mbx_base | output | 16 | Device 9 I/O base |

## Verification
The assertions assume the host never raises the read and write strobes together, and that reset is held for at least one clock edge before the first access. The random bench draws one operation per cycle, chosen as a read, a write or idle, so the strobes are never both high.

Indices, device numbers and data bytes are drawn with a bias towards the keys, the implemented indices and the device numbers 5 and 9. This bias makes key sequences and bank switches frequent. A reference model in the bench predicts every read byte and every output.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   typedef enum logic {LK_CLOSED = 1'b0, LK_OPEN = 1'b1} lock_state_e;

   localparam logic [7:0] IDX_CHIP_ID = 8'h00;
   localparam logic [7:0] IDX_LDN     = 8'h07;
   localparam logic [7:0] IDX_PB_LO   = 8'h26;
   localparam logic [7:0] IDX_PB_HI   = 8'h27;
   localparam logic [7:0] IDX_ENABLE  = 8'h30;
   localparam logic [7:0] IDX_IOB_HI  = 8'h60;
   localparam logic [7:0] IDX_IOB_LO  = 8'h61;
   localparam logic [7:0] IDX_IRQ     = 8'h70;
endpackage

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] UNLOCK_KEY = 8'h5A,
   parameter logic [7:0] LOCK_KEY   = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic       idx_load,
   output logic       idx_clear
);
   lock_state_e state_q, state_d;

   if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_keys
      $error("sio_cfg_lock: keys must differ");
   end

   always_comb begin
      state_d = state_q;
      if (idx_wr) begin
         if (state_q == LK_CLOSED && wdata == UNLOCK_KEY) state_d = LK_OPEN;
         else if (state_q == LK_OPEN && wdata == LOCK_KEY) state_d = LK_CLOSED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LK_CLOSED;
      else        state_q <= state_d;
   end

   assign open      = (state_q == LK_OPEN);
   assign idx_load  = open && idx_wr && (wdata != LOCK_KEY);
   assign idx_clear = !open && idx_wr && (wdata == UNLOCK_KEY);

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && idx_wr && wdata == UNLOCK_KEY) |=> open); // R2
   AST_OTHER_STAYS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && !(idx_wr && wdata == UNLOCK_KEY)) |=> !open); // R2
   AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (open && idx_wr && wdata == LOCK_KEY) |=> !open); // R3
endmodule

// File: rtl/sio_cfg_ldev_bank.sv
module sio_cfg_ldev_bank
   import sio_cfg_pkg::*;
#(
   parameter bit HAS_IRQ = 1'b0,
   parameter int IRQ_W   = 4,
   parameter int BASE_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [7:0]        idx,
   input  logic [7:0]        wdata,
   output logic              enable,
   output logic [BASE_W-1:0] base,
   output logic [IRQ_W-1:0]  irq,
   output logic [7:0]        rd_data
);
   if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irq_w
      $error("sio_cfg_ldev_bank: IRQ_W must be 1..8");
   end
   if (BASE_W != 16) begin : g_bad_base_w
      $error("sio_cfg_ldev_bank: BASE_W must be 16");
   end

   logic bank_wr;
   assign bank_wr = sel && wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= 1'b0;
         base   <= '0;
      end else if (bank_wr) begin
         if (idx == IDX_ENABLE) enable      <= wdata[0];
         if (idx == IDX_IOB_HI) base[15:8]  <= wdata;
         if (idx == IDX_IOB_LO) base[7:0]   <= wdata;
      end
   end

   logic [7:0] irq_rd;
   if (HAS_IRQ) begin : g_irq
      logic [IRQ_W-1:0] irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          irq_q <= '0;
         else if (bank_wr && idx == IDX_IRQ)  irq_q <= wdata[IRQ_W-1:0];
      end
      assign irq    = irq_q;
      assign irq_rd = 8'(irq_q);

      AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(bank_wr && idx == IDX_IRQ) |=> $stable(irq)); // R11
   end else begin : g_no_irq
      assign irq    = '0;
      assign irq_rd = 8'h00;
   end

   always_comb begin
      unique case (idx)
         IDX_ENABLE: rd_data = {7'b0, enable};
         IDX_IOB_HI: rd_data = base[15:8];
         IDX_IOB_LO: rd_data = base[7:0];
         IDX_IRQ:    rd_data = irq_rd;
         default:    rd_data = 8'h00;
      endcase
   end

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_wr |=> ($stable(base) && $stable(enable))); // R12
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0]  CHIP_ID    = 8'hB7,
   parameter logic [15:0] PORT_BASE  = 16'h002E,
   parameter logic [7:0]  UNLOCK_KEY = 8'h5A,
   parameter logic [7:0]  LOCK_KEY   = 8'hA5,
   parameter logic [7:0]  IR_LDN     = 8'h05,
   parameter logic [7:0]  MBX_LDN    = 8'h09,
   parameter int          IRQ_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_addr,
   input  logic             host_rd,
   input  logic             host_wr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             ir_enable,
   output logic [15:0]      ir_base,
   output logic [IRQ_W-1:0] ir_irq,
   output logic             mbx_enable,
   output logic [15:0]      mbx_base
);
   localparam int NUM_LDEV = 2;
   localparam logic [7:0] LDEV_NUM [NUM_LDEV] = '{IR_LDN, MBX_LDN};

   if (IR_LDN == MBX_LDN) begin : g_bad_ldn
      $error("sio_cfg_port: device numbers must differ");
   end

   logic       open, idx_load, idx_clear;
   logic [7:0] index_q, ldn_q;
   logic       data_wr;

   sio_cfg_lock #(.UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(host_wr && !host_addr), .wdata(host_wdata),
      .open(open), .idx_load(idx_load), .idx_clear(idx_clear));

   assign data_wr = open && host_wr && host_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= 8'h00;
         ldn_q   <= 8'h00;
      end else begin
         if (idx_clear)     index_q <= 8'h00;
         else if (idx_load) index_q <= host_wdata;
         if (data_wr && index_q == IDX_LDN) ldn_q <= host_wdata;
      end
   end

   logic [NUM_LDEV-1:0] dev_sel, dev_en;
   logic [15:0]         dev_base [NUM_LDEV];
   logic [7:0]          dev_rd   [NUM_LDEV];
   logic [IRQ_W-1:0]    dev_irq  [NUM_LDEV];

   for (genvar g = 0; g < NUM_LDEV; g++) begin : g_dev
      assign dev_sel[g] = (ldn_q == LDEV_NUM[g]);
      sio_cfg_ldev_bank #(.HAS_IRQ(g == 0), .IRQ_W(IRQ_W), .BASE_W(16)) u_bank (
         .clk(clk), .rst_n(rst_n), .sel(dev_sel[g]), .wr_en(data_wr),
         .idx(index_q), .wdata(host_wdata),
         .enable(dev_en[g]), .base(dev_base[g]), .irq(dev_irq[g]),
         .rd_data(dev_rd[g]));
   end

   logic [IRQ_W-1:0] mbx_irq_unused;
   assign mbx_irq_unused = dev_irq[1];

   assign ir_enable  = dev_en[0];
   assign ir_base    = dev_base[0];
   assign ir_irq     = dev_irq[0];
   assign mbx_enable = dev_en[1];
   assign mbx_base   = dev_base[1];

   logic [7:0] bank_rd;
   always_comb begin
      bank_rd = 8'h00;
      for (int i = 0; i < NUM_LDEV; i++)
         if (dev_sel[i]) bank_rd = dev_rd[i];
   end

   always_comb begin
      if (!open)          host_rdata = 8'hFF;
      else if (!host_addr) host_rdata = index_q;
      else begin
         unique case (index_q)
            IDX_CHIP_ID: host_rdata = CHIP_ID;
            IDX_LDN:     host_rdata = ldn_q;
            IDX_PB_LO:   host_rdata = PORT_BASE[7:0];
            IDX_PB_HI:   host_rdata = PORT_BASE[15:8];
            default:     host_rdata = bank_rd;
         endcase
      end
   end

   AST_CLOSED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && host_rd) |-> host_rdata == 8'hFF); // R4
   AST_CLOSED_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(ldn_q)); // R4
   AST_OPEN_CLEARS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && host_wr && !host_addr && host_wdata == UNLOCK_KEY) |=> index_q == 8'h00); // R5
   AST_CHIP_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (open && host_rd && host_addr && index_q == IDX_CHIP_ID) |-> host_rdata == CHIP_ID); // R6
   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel)); // R8
endmodule

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_addr = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       ir_enable, mbx_enable;
   logic [15:0] ir_base, mbx_base;
   logic [3:0] ir_irq;

   int total = 0, bad = 0;

   always #2 clk = ~clk;

   sio_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ir_enable(ir_enable), .ir_base(ir_base), .ir_irq(ir_irq),
      .mbx_enable(mbx_enable), .mbx_base(mbx_base));

   // reference model
   bit         m_open;
   logic [7:0] m_idx, m_ldn;
   bit         m_en [2];
   logic [15:0] m_base [2];
   logic [3:0] m_irq;

   function automatic void model_reset();
      m_open = 0; m_idx = 0; m_ldn = 0; m_irq = 0;
      for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_base[i] = 0; end
   endfunction

   function automatic int dev_of(logic [7:0] ldn);
      if (ldn == 8'h05) return 0;
      if (ldn == 8'h09) return 1;
      return -1;
   endfunction

   function automatic logic [7:0] exp_read(logic a);
      int d;
      if (!m_open) return 8'hFF;
      if (!a) return m_idx;
      d = dev_of(m_ldn);
      case (m_idx)
         8'h00: return 8'hB7;
         8'h07: return m_ldn;
         8'h26: return 8'h2E;
         8'h27: return 8'h00;
         8'h30: return (d < 0) ? 8'h00 : {7'b0, m_en[d]};
         8'h60: return (d < 0) ? 8'h00 : m_base[d][15:8];
         8'h61: return (d < 0) ? 8'h00 : m_base[d][7:0];
         8'h70: return (d == 0) ? {4'b0, m_irq} : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(logic a);
      if (!m_open) return "R4";
      if (!a) return "R5";
      case (m_idx)
         8'h00: return "R6";
         8'h07: return "R8";
         8'h26, 8'h27: return "R7";
         8'h30: return (dev_of(m_ldn) < 0) ? "R12" : "R9";
         8'h60, 8'h61: return (dev_of(m_ldn) < 0) ? "R12" : "R10";
         8'h70: return "R11";
         default: return "R12";
      endcase
   endfunction

   function automatic void model_write(logic a, logic [7:0] d);
      int k;
      if (!a) begin
         if (!m_open) begin
            if (d == 8'h5A) begin m_open = 1; m_idx = 0; end
         end else if (d == 8'hA5) m_open = 0;
         else m_idx = d;
         return;
      end
      if (!m_open) return;
      k = dev_of(m_ldn);
      case (m_idx)
         8'h07: m_ldn = d;
         8'h30: if (k >= 0) m_en[k] = d[0];
         8'h60: if (k >= 0) m_base[k][15:8] = d;
         8'h61: if (k >= 0) m_base[k][7:0] = d;
         8'h70: if (k == 0) m_irq = d[3:0];
         default: ;
      endcase
   endfunction

   task automatic check8(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      check8(tag, {15'b0, ir_enable}, {15'b0, m_en[0]});
      check8(tag, ir_base, m_base[0]);
      check8(tag, {12'b0, ir_irq}, {12'b0, m_irq});
      check8(tag, {15'b0, mbx_enable}, {15'b0, m_en[1]});
      check8(tag, mbx_base, m_base[1]);
   endtask

   task automatic op_rd(logic a);
      @(negedge clk);
      host_addr = a; host_rd = 1; host_wr = 0;
      #1 check8(tag_of(a), {8'h00, host_rdata}, {8'h00, exp_read(a)}); // R13
      @(negedge clk); host_rd = 0;
   endtask

   task automatic op_wr(logic a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wr = 1; host_rd = 0; host_wdata = d;
      @(posedge clk); model_write(a, d);
      @(negedge clk); host_wr = 0;
   endtask

   task automatic cfg(logic [7:0] i, logic [7:0] d);
      op_wr(0, i); op_wr(1, d);
   endtask

   function automatic logic [7:0] pick_idx();
      logic [7:0] set [10] = '{8'h00, 8'h07, 8'h26, 8'h27, 8'h30, 8'h60, 8'h61, 8'h70, 8'h5A, 8'hA5};
      int r = $urandom_range(0, 12);
      return (r < 10) ? set[r] : 8'($urandom);
   endfunction

   function automatic logic [7:0] pick_data();
      int r = $urandom_range(0, 5);
      case (r)
         0: return 8'h05;
         1: return 8'h09;
         2: return 8'h5A;
         3: return 8'hA5;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      #(4 * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5105_C0DE));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      check_outputs("R1");
      op_rd(1); // closed read -> FF (R4)
      // R2: wrong key keeps closed
      op_wr(0, 8'h55); op_rd(0);
      op_wr(1, 8'h07); op_wr(0, 8'hA5); op_rd(1);
      // R2 open, R5 index cleared
      op_wr(0, 8'h5A); op_rd(0);
      check8("R1", {8'h00, host_rdata}, 16'h0000);
      cfg(8'h00, 8'h12); op_rd(1);                    // R6
      op_wr(0, 8'h26); op_rd(1); op_wr(0, 8'h27); op_rd(1); // R7
      cfg(8'h07, 8'h05);                               // R8
      cfg(8'h30, 8'hFF); cfg(8'h60, 8'h12); cfg(8'h61, 8'h34); cfg(8'h70, 8'hAB);
      op_rd(1); check_outputs("R9");                   // R9 R10 R11
      cfg(8'h07, 8'h09); cfg(8'h70, 8'h07); op_rd(1);  // R11 mailbox no irq
      cfg(8'h60, 8'hBE); cfg(8'h61, 8'hEF); op_rd(1); check_outputs("R10");
      cfg(8'h07, 8'h03); cfg(8'h30, 8'h01); op_rd(1); check_outputs("R12");
      // R3 close, R4 writes ignored
      op_wr(0, 8'hA5); op_rd(0);
      op_wr(1, 8'h00); check_outputs("R4");
      op_wr(0, 8'h5A);
      // constrained random
      for (int n = 0; n < 4000; n++) begin
         int kind = $urandom_range(0, 9);
         if (kind < 4)      op_rd(1'($urandom_range(0, 1)));
         else if (kind < 7) op_wr(0, pick_idx());
         else if (kind < 9) op_wr(1, pick_data());
         else @(negedge clk);
         if (n % 16 == 0) check_outputs("R13");
      end
      disable watchdog;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule